// File: doc/BRIEF.md
# Bit Test and Branch Unit

This unit carries out the bit-test-and-branch instruction class of an 8-bit microcontroller core. The decode stage hands it one instruction at a time. Each instruction brings four items: the opcode, the byte that names the location under test, the signed branch displacement, and the address where the opcode was fetched. The unit then asks memory for the byte under test. That address always lies in the bottom 256 locations. It waits for the byte to come back and picks the bit that the opcode names. It returns the program counter for the next instruction, a taken flag and the tested bit, which the core writes into its carry flag.

The opcode gives both the bit number and the polarity that causes a branch. The instruction is always three bytes long. So the fall-through address is the opcode address plus three. The branch target is that value plus the sign-extended displacement, which gives a reach of -125 to +130 bytes around the opcode. The memory side uses a request/ready handshake followed by a data-valid strobe. Completion is signalled by a single-cycle pulse.

Top module: `btb_unit`

## Requirements
- R1: After reset, `done`, `rd_req`, `busy`, `taken` and `carry_out` are 0 and `next_pc` is 0.
- R2: `start` is accepted only while `busy` is 0. A `start` seen while `busy` is 1 has no effect: the instruction in progress completes with its own operands.
- R3: From the cycle after acceptance, `rd_req` is 1 and `rd_addr` equals the direct-address byte with zeros above it. Both hold unchanged until a cycle in which `rd_ready` is 1.
- R4: `rd_valid` is acted on only after the request has been accepted. A strobe before that point, or while idle, changes no output.
- R5: The tested bit is `rd_data[opcode[3:1]]`. Opcode bit 0 = 0 means branch if that bit is 1, and opcode bit 0 = 1 means branch if it is 0.
- R6: When the branch is not taken, `next_pc` = opcode address + 3, modulo 2^PC_W.
- R7: When the branch is taken, `next_pc` = opcode address + 3 + the sign-extended offset byte, modulo 2^PC_W.
- R8: `carry_out` equals the tested bit whether or not the branch is taken.
- R9: `done` is 1 for exactly one cycle, the cycle after the accepted `rd_valid`. `next_pc`, `taken` and `carry_out` keep their values until the next `done`.
- R10: `rd_req` rises in the cycle right after `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Presents a new instruction |
| opcode | input | 8 | Opcode; [3:1] bit number, [0] polarity |
| dir_addr | input | 8 | Address byte of the location under test |
| rel_ofs | input | 8 | Signed branch displacement |
| op_pc | input | 16 | Address of the opcode byte |
| busy | output | 1 | Instruction in progress |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 16 | Read address, always below 256 |
| rd_ready | input | 1 | Memory accepts the request |
| rd_valid | input | 1 | Read data is valid |
| rd_data | input | 8 | Byte read back |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | 16 | Next program counter |
| taken | output | 1 | Branch was taken |
| carry_out | output | 1 | Value of the tested bit |

## Verification
The bench tries every bit number with both polarities. A design with a swapped or shifted bit index, or with inverted sense, would branch the wrong way and report the wrong carry. The displacement cases use the most negative offset, the most positive offset, and a target that wraps past the top of the address space. A design that zero-extends the offset or drops the carry-out of the adder would land at the wrong address. Handshake cases stall `rd_ready` and `rd_valid` for several cycles and drive a false data strobe and a second `start` while a request is pending. A design that took the early data, or restarted on the second start, would finish early or with the wrong operands.

// File: rtl/btb_pkg.sv
package btb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } btb_state_e;
endpackage

// File: rtl/btb_decode.sv
module btb_decode #(
   parameter int OP_W   = 8,
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [OP_W-1:0]  opcode,
   output logic [IDX_W-1:0] bit_idx,
   output logic             br_if_clr
);
   // field layout: [IDX_W:1] bit number, [0] polarity
   assign bit_idx   = opcode[IDX_W:1];
   assign br_if_clr = opcode[0];
endmodule

// File: rtl/btb_bitsel.sv
module btb_bitsel #(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [IDX_W-1:0]  idx,
   output logic              bit_val
);
   logic [DATA_W-1:0] hit;
   for (genvar g = 0; g < DATA_W; g++) begin : g_lane
      assign hit[g] = data[g] & (idx == IDX_W'(g));
   end
   assign bit_val = |hit;
endmodule

// File: rtl/btb_target.sv
module btb_target #(
   parameter int PC_W     = 16,
   parameter int DATA_W   = 8,
   parameter int INSN_LEN = 3
) (
   input  logic [PC_W-1:0]   op_pc,
   input  logic [DATA_W-1:0] rel_ofs,
   output logic [PC_W-1:0]   seq_pc,
   output logic [PC_W-1:0]   tgt_pc
);
   logic [PC_W-1:0] ofs_ext;
   if (PC_W > DATA_W) begin : g_sext
      assign ofs_ext = {{(PC_W-DATA_W){rel_ofs[DATA_W-1]}}, rel_ofs};
   end else begin : g_same
      assign ofs_ext = rel_ofs[PC_W-1:0];
   end
   assign seq_pc = op_pc + PC_W'(INSN_LEN);
   assign tgt_pc = seq_pc + ofs_ext;
endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl
   import btb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rd_ready,
   input  logic rd_valid,
   output logic busy,
   output logic rd_req,
   output logic capture,
   output logic finish
);
   btb_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (start)    state_d = ST_REQ;
         ST_REQ:  if (rd_ready) state_d = ST_WAIT;
         ST_WAIT: if (rd_valid) state_d = ST_IDLE;
         default:               state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign busy    = (state_q != ST_IDLE);
   assign rd_req  = (state_q == ST_REQ);
   assign capture = (state_q == ST_IDLE) && start;
   assign finish  = (state_q == ST_WAIT) && rd_valid;
endmodule

// File: rtl/btb_unit.sv
module btb_unit #(
   parameter int OP_W     = 8,
   parameter int DATA_W   = 8,
   parameter int PC_W     = 16,
   parameter int INSN_LEN = 3,
   localparam int IDX_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   opcode,
   input  logic [DATA_W-1:0] dir_addr,
   input  logic [DATA_W-1:0] rel_ofs,
   input  logic [PC_W-1:0]   op_pc,
   output logic              busy,
   output logic              rd_req,
   output logic [PC_W-1:0]   rd_addr,
   input  logic              rd_ready,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic [PC_W-1:0]   next_pc,
   output logic              taken,
   output logic              carry_out
);
   if (PC_W < DATA_W + 1) begin : g_bad_pc
      $error("btb_unit: PC_W must exceed DATA_W");
   end
   if (OP_W < IDX_W + 1) begin : g_bad_op
      $error("btb_unit: OP_W too narrow for bit field");
   end
   if ((1 << IDX_W) != DATA_W) begin : g_bad_data
      $error("btb_unit: DATA_W must be a power of two");
   end

   logic              capture, finish;
   logic [IDX_W-1:0]  idx_d, idx_q;
   logic              clr_d, clr_q;
   logic [DATA_W-1:0] addr_q, ofs_q;
   logic [PC_W-1:0]   pc_q, seq_pc, tgt_pc;
   logic              bit_val, go;

   btb_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rd_ready(rd_ready), .rd_valid(rd_valid),
      .busy(busy), .rd_req(rd_req), .capture(capture), .finish(finish)
   );

   btb_decode #(.OP_W(OP_W), .DATA_W(DATA_W)) u_dec (
      .opcode(opcode), .bit_idx(idx_d), .br_if_clr(clr_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         clr_q  <= 1'b0;
         addr_q <= '0;
         ofs_q  <= '0;
         pc_q   <= '0;
      end else if (capture) begin
         idx_q  <= idx_d;
         clr_q  <= clr_d;
         addr_q <= dir_addr;
         ofs_q  <= rel_ofs;
         pc_q   <= op_pc;
      end
   end

   assign rd_addr = {{(PC_W-DATA_W){1'b0}}, addr_q};

   btb_bitsel #(.DATA_W(DATA_W)) u_sel (
      .data(rd_data), .idx(idx_q), .bit_val(bit_val)
   );

   btb_target #(.PC_W(PC_W), .DATA_W(DATA_W), .INSN_LEN(INSN_LEN)) u_tgt (
      .op_pc(pc_q), .rel_ofs(ofs_q), .seq_pc(seq_pc), .tgt_pc(tgt_pc)
   );

   assign go = bit_val ^ clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         next_pc   <= '0;
         taken     <= 1'b0;
         carry_out <= 1'b0;
      end else begin
         done <= finish;
         if (finish) begin
            next_pc   <= go ? tgt_pc : seq_pc;
            taken     <= go;
            carry_out <= bit_val;
         end
      end
   end
endmodule

// File: rtl/btb_unit_chk.sv
module btb_unit_chk #(
   parameter int OP_W     = 8,
   parameter int DATA_W   = 8,
   parameter int PC_W     = 16,
   parameter int INSN_LEN = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [OP_W-1:0]   opcode,
   input logic [DATA_W-1:0] rel_ofs,
   input logic [PC_W-1:0]   op_pc,
   input logic              busy,
   input logic              rd_req,
   input logic [PC_W-1:0]   rd_addr,
   input logic              rd_ready,
   input logic              done,
   input logic [PC_W-1:0]   next_pc,
   input logic              taken,
   input logic              carry_out
);
   logic [PC_W-1:0] exp_seq, exp_tgt;
   logic            pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_seq <= '0;
         exp_tgt <= '0;
         pol_q   <= 1'b0;
      end else if (start && !busy) begin
         exp_seq <= op_pc + PC_W'(INSN_LEN);
         exp_tgt <= op_pc + PC_W'(INSN_LEN) + PC_W'($signed(rel_ofs));
         pol_q   <= opcode[0];
      end
   end

   AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
   AST_REQ_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) rd_req && !rd_ready |=> rd_req && $stable(rd_addr)); // R3
   AST_REQ_PAGE:     assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> rd_addr < PC_W'(1 << DATA_W)); // R3
   AST_START_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> rd_req); // R10
   AST_SEQ_PC:       assert property (@(posedge clk) disable iff (!rst_n) done && !taken |-> next_pc == exp_seq); // R6
   AST_TGT_PC:       assert property (@(posedge clk) disable iff (!rst_n) done && taken |-> next_pc == exp_tgt); // R7
   AST_SENSE:        assert property (@(posedge clk) disable iff (!rst_n) done |-> taken == (carry_out ^ pol_q)); // R5
   AST_RESULT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !done |=> done || ($stable(next_pc) && $stable(taken))); // R9
endmodule

bind btb_unit btb_unit_chk #(.OP_W(OP_W), .DATA_W(DATA_W), .PC_W(PC_W), .INSN_LEN(INSN_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .rel_ofs(rel_ofs),
   .op_pc(op_pc), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
   .rd_ready(rd_ready), .done(done), .next_pc(next_pc), .taken(taken),
   .carry_out(carry_out)
);

// File: tb/btb_unit_bench.sv
`timescale 1ns/1ps
module btb_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = '0, dir_addr = '0, rel_ofs = '0, rd_data = '0;
   logic [15:0] op_pc = '0;
   logic        rd_ready = 1'b0, rd_valid = 1'b0;
   logic        busy, rd_req, done, taken, carry_out;
   logic [15:0] rd_addr, next_pc;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   btb_unit u_btb_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .dir_addr(dir_addr), .rel_ofs(rel_ofs), .op_pc(op_pc),
      .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .done(done), .next_pc(next_pc), .taken(taken), .carry_out(carry_out)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   // one instruction, with stall counts and optional disturbances
   task automatic run_insn(input logic [7:0] op, input logic [7:0] da,
                           input logic [7:0] ofs, input logic [15:0] pc,
                           input logic [7:0] data, input int rdly,
                           input int vdly, input bit junk, input bit inject);
      logic        bitv, go;
      logic [15:0] exp_pc;
      bitv   = data[op[3:1]];
      go     = op[0] ? !bitv : bitv;
      exp_pc = pc + 16'd3 + (go ? {{8{ofs[7]}}, ofs} : 16'd0);

      @(negedge clk);
      start = 1'b1; opcode = op; dir_addr = da; rel_ofs = ofs; op_pc = pc;
      @(negedge clk);
      start = 1'b0;
      chk("R10 rd_req after start", rd_req, 1'b1);
      chk("R3 rd_addr", rd_addr, {8'h00, da});
      if (inject) begin
         start = 1'b1; opcode = op ^ 8'h01; op_pc = pc + 16'h0100; rel_ofs = ~ofs;
      end
      for (int i = 0; i < rdly; i++) begin
         if (junk && i == 0) begin rd_valid = 1'b1; rd_data = ~data; end
         @(negedge clk);
         start = 1'b0; rd_valid = 1'b0;
         chk("R3 rd_req held", rd_req, 1'b1);
         chk("R4 no early done", done, 1'b0);
      end
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0; start = 1'b0;
      chk("R3 rd_req dropped", rd_req, 1'b0);
      for (int i = 0; i < vdly; i++) begin
         @(negedge clk);
         chk("R4 wait for data", done, 1'b0);
         chk("R2 still busy", busy, 1'b1);
      end
      rd_valid = 1'b1; rd_data = data;
      @(negedge clk);
      rd_valid = 1'b0; rd_data = 8'h5A;
      chk("R9 done pulse", done, 1'b1);
      chk(go ? "R7 taken pc" : "R6 seq pc", next_pc, exp_pc);
      chk("R5 taken", taken, go);
      chk("R8 carry", carry_out, bitv);
      @(negedge clk);
      chk("R9 done one cycle", done, 1'b0);
      chk("R9 pc held", next_pc, exp_pc);
      chk("R2 idle after", busy, 1'b0);
   endtask

   task automatic t_reset;
      chk("R1 done", done, 1'b0);
      chk("R1 rd_req", rd_req, 1'b0);
      chk("R1 busy", busy, 1'b0);
      chk("R1 next_pc", next_pc, 16'h0000);
      chk("R1 taken", taken, 1'b0);
      chk("R1 carry", carry_out, 1'b0);
   endtask

   task automatic t_polarity;
      run_insn(8'h04, 8'h40, 8'h10, 16'h1000, 8'h04, 0, 0, 0, 0); // set, taken
      run_insn(8'h0E, 8'h41, 8'h10, 16'h2000, 8'h7F, 0, 0, 0, 0); // set, not taken
      run_insn(8'h01, 8'h42, 8'h80, 16'h3000, 8'hFE, 0, 0, 0, 0); // clear, taken, -128
      run_insn(8'h0B, 8'h43, 8'h20, 16'h4000, 8'h20, 0, 0, 0, 0); // clear, not taken
   endtask

   task automatic t_reach;
      run_insn(8'h00, 8'hFF, 8'h7F, 16'hFFF0, 8'h01, 1, 1, 0, 0); // wrap forward
      run_insn(8'h00, 8'h00, 8'h80, 16'h0010, 8'h01, 0, 2, 0, 0); // wrap backward
   endtask

   task automatic t_handshake;
      run_insn(8'h06, 8'h77, 8'hF0, 16'h5000, 8'h08, 3, 4, 1, 1);
   endtask

   task automatic t_stray_valid;
      logic [15:0] pc_before;
      pc_before = next_pc;
      @(negedge clk);
      rd_valid = 1'b1; rd_data = 8'hFF;
      @(negedge clk);
      rd_valid = 1'b0;
      chk("R4 stray valid no done", done, 1'b0);
      chk("R4 stray valid no busy", busy, 1'b0);
      @(negedge clk);
      chk("R4 stray valid pc", next_pc, pc_before);
   endtask

   task automatic t_all_bits;
      for (int b = 0; b < 8; b++) begin
         for (int s = 0; s < 2; s++) begin
            run_insn({4'h0, 3'(b), 1'(s)}, 8'(b * 16 + s), 8'(b * 5 - 20),
                     16'(16'h6000 + b * 64), 8'(8'hA5 << (b % 3)), s, b % 2, 0, 0);
         end
      end
   endtask

   initial begin
      #1;
      t_reset;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_polarity;
      t_reach;
      t_handshake;
      t_stray_valid;
      t_all_bits;
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule